// File: doc/BRIEF.md
# Burst Address Generator

This block produces the internal address for one port of a synchronous memory. At every rising clock edge it either clears itself, takes a new start address from outside, steps to the next word, or keeps its value. A controller starts a burst by presenting an address with the active-low strobe. It then holds the active-low count enable low to walk through consecutive words without driving the address bus again. It releases the enable to pause the burst.

The address is a registered output that feeds the address register in front of the array decoder. The counter covers the whole array. After the highest word it rolls over to word zero. When more than one control is active in the same cycle, the clear input wins over a load, a load wins over a step, and a step wins over holding.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `addr_q` becomes 0 after that edge.
- R2: When `clear_n` is low at a rising edge, `addr_q` becomes 0 after that edge, whatever `strobe_n`, `count_n` and `ext_addr` are.
- R3: When `strobe_n` is low and `clear_n` is high at a rising edge, `addr_q` takes the value of `ext_addr` after that edge, and `count_n` has no effect in that cycle.
- R4: When `count_n` is low and both `strobe_n` and `clear_n` are high at a rising edge, `addr_q` increases by exactly one.
- R5: When `clear_n`, `strobe_n` and `count_n` are all high at a rising edge, `addr_q` keeps its value.
- R6: A step from the all-ones address (2^AW - 1) gives address 0.
- R7: After a load, the loaded address is the output for that access cycle, and the first step happens at the next edge that has `count_n` low.
- R8: `ext_addr` has no effect on `addr_q` unless `strobe_n` is low and `clear_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock. All inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low block reset |
| ext_addr | input | AW | External start address for a burst |
| strobe_n | input | 1 | Active-low load strobe for `ext_addr` |
| count_n | input | 1 | Active-low count enable that steps the address |
| clear_n | input | 1 | Active-low clear of the address to zero |
| addr_q | output | AW | Registered internal address |

## Verification
The properties assume that `clear_n`, `strobe_n` and `count_n` always hold defined levels. They also assume that reset is held across at least one rising edge before checking starts, so the first previous address seen by a property is the reset value. The bench drives every control to a known level from time zero and keeps reset low for several edges. It changes inputs only on falling edges, so each rising edge sees a single stable combination of controls.

// File: rtl/bag_pkg.sv
// Shared types for the burst address generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bag_pkg;

    // One action per clock edge; encoding order has no meaning outside the block.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } bag_op_e;

endpackage

// File: rtl/bag_op_sel.sv
// Priority selector: turns the three active-low controls into one action.
// Assumes: controls are stable around the rising edge; priority is
// clear > load > step > hold.
module bag_op_sel
    import bag_pkg::*;
(
    input  logic    clear_n,
    input  logic    strobe_n,
    input  logic    count_n,
    output bag_op_e op
);

    // Pick the highest-priority active control.
    always_comb begin
        if (!clear_n)       op = OP_CLEAR;
        else if (!strobe_n) op = OP_LOAD;
        else if (!count_n)  op = OP_STEP;
        else                op = OP_HOLD;
    end

endmodule

// File: rtl/bag_next.sv
// Next-address logic: computes the value the register takes at the next edge.
// Assumes: the step wraps modulo 2^AW by dropping the carry out.
module bag_next
    import bag_pkg::*;
#(
    parameter int AW = 16
) (
    input  bag_op_e       op,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] ext,
    output logic [AW-1:0] nxt
);

    localparam logic [AW-1:0] ONE  = AW'(1);
    localparam logic [AW-1:0] ZERO = '0;

    logic [AW-1:0] stepped;

    // Incrementer; the carry out of the top bit is dropped, which gives the wrap.
    assign stepped = cur + ONE;

    // Choose the next address from the selected action.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = ZERO;
            OP_LOAD:  nxt = ext;
            OP_STEP:  nxt = stepped;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/bag_addr_reg.sv
// Address register with synchronous active-low reset.
// Assumes: rst_n is sampled on the rising edge like every other input.
module bag_addr_reg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);

    // Store the next address, or zero while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Per-port burst address generator: load, step, clear or hold on each edge.
// Assumes: one clock per port; the output feeds the decoder address register.
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          strobe_n,
    input  logic          count_n,
    input  logic          clear_n,
    output logic [AW-1:0] addr_q
);

    bag_op_e       op;
    logic [AW-1:0] nxt;

    bag_op_sel u_sel (
        .clear_n  (clear_n),
        .strobe_n (strobe_n),
        .count_n  (count_n),
        .op       (op)
    );

    bag_next #(.AW(AW)) u_next (
        .op  (op),
        .cur (addr_q),
        .ext (ext_addr),
        .nxt (nxt)
    );

    bag_addr_reg #(.AW(AW)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (addr_q)
    );

endmodule

// File: rtl/bag_chk.sv
// Property checker for burst_addr_gen, attached with bind below.
// Assumes: controls are never X while rst_n is high.
module bag_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ext_addr,
    input logic          strobe_n,
    input logic          count_n,
    input logic          clear_n,
    input logic [AW-1:0] addr_q
);

    localparam logic [AW-1:0] ALL1 = '1;

    // R2: clear beats every other control
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |=> addr_q == '0);

    // R3: load takes the external address
    a_r3_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && !strobe_n) |=> addr_q == $past(ext_addr));

    // R4: plain step adds one
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && !count_n) |=> addr_q == AW'($past(addr_q) + AW'(1)));

    // R5: no control active keeps the address
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && count_n) |=> $stable(addr_q));

    // R6: step from all-ones rolls over to zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && !count_n && addr_q == ALL1) |=> addr_q == '0);

endmodule

bind burst_addr_gen bag_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .strobe_n (strobe_n),
    .count_n  (count_n),
    .clear_n  (clear_n),
    .addr_q   (addr_q)
);

// File: tb/sim_burst_addr_gen.sv
// Directed bench for burst_addr_gen: one task per scenario.
module sim_burst_addr_gen;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1'b1;
    logic          count_n = 1'b1;
    logic          clear_n = 1'b1;
    logic [AW-1:0] addr_q;

    int n_chk = 0;
    int n_bad = 0;

    burst_addr_gen #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .strobe_n(strobe_n), .count_n(count_n), .clear_n(clear_n),
        .addr_q(addr_q)
    );

    always #4 clk = ~clk;

    // Compare one output value against the expected one.
    task automatic chk(input logic [AW-1:0] exp, input string req);
        n_chk++;
        if (addr_q !== exp) begin
            n_bad++;
            $display("FAIL %s: addr_q=%h expected=%h", req, addr_q, exp);
        end
    endtask

    // Apply controls at a falling edge, then settle just after the next rising edge.
    task automatic cyc(input logic s, input logic c, input logic k, input logic [AW-1:0] a);
        @(negedge clk);
        strobe_n = s; count_n = c; clear_n = k; ext_addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(1, 0, 1, 16'h1234);
        cyc(0, 1, 1, 16'h5555);
        chk('0, "R1 reset holds zero");
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_load_and_burst();
        cyc(0, 1, 1, 16'h0100);
        chk(16'h0100, "R3 load");
        cyc(1, 0, 1, 16'h0000);
        chk(16'h0101, "R7 first step after load");
        cyc(1, 0, 1, 16'h0000);
        chk(16'h0102, "R4 step");
        cyc(1, 0, 1, 16'h0000);
        chk(16'h0103, "R4 step");
    endtask

    task automatic t_hold();
        cyc(1, 1, 1, 16'hBEEF);
        chk(16'h0103, "R5 hold");
        cyc(1, 1, 1, 16'h0F0F);
        chk(16'h0103, "R8 ext ignored while holding");
        cyc(1, 0, 1, 16'hFFFF);
        chk(16'h0104, "R8 ext ignored while stepping");
    endtask

    task automatic t_load_beats_step();
        cyc(0, 0, 1, 16'h2000);
        chk(16'h2000, "R3 load wins over step");
        cyc(1, 0, 1, 16'h0000);
        chk(16'h2001, "R7 step starts next cycle");
    endtask

    task automatic t_clear();
        cyc(0, 0, 0, 16'h7777);
        chk('0, "R2 clear wins over load and step");
        cyc(1, 1, 1, 16'h3333);
        chk('0, "R5 hold after clear");
        cyc(1, 0, 1, 16'h0000);
        chk(16'h0001, "R4 step from zero");
    endtask

    task automatic t_wrap();
        cyc(0, 1, 1, 16'hFFFE);
        chk(16'hFFFE, "R3 load near top");
        cyc(1, 0, 1, 16'h0000);
        chk(16'hFFFF, "R4 step to top");
        cyc(1, 0, 1, 16'h0000);
        chk(16'h0000, "R6 wrap to zero");
        cyc(1, 0, 1, 16'h0000);
        chk(16'h0001, "R6 continue after wrap");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                t_reset();
                t_load_and_burst();
                t_hold();
                t_load_beats_step();
                t_clear();
                t_wrap();
                t_reset();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule